// File: doc/BRIEF.md
# Ringing Cadence Sequencer

This block turns a steady "ring the line" request into bursts of ringing separated by silent gaps. Two timers measure the lengths of the burst and the gap in 1 ms ticks taken from a shared timebase strobe. Each timer has its own enable bit, and each has a 13-bit duration word, so either phase can last up to 8191 ms. While the line-state input selects ringing, the block moves between a ringing phase and an on-hook transmission phase. It drives a gate signal that turns the waveform generator on and off, and it reports the current phase on a two-bit state output.

Software first programs the durations and the enables, then selects the ringing line state. Ringing starts on the next clock edge. Each time a timer runs out, the block raises a one-cycle interrupt pulse and moves to the other phase. If the duration timer for bursts is disabled, ringing never stops. If only the gap timer is disabled, the line stays silent after the first burst. When ringing is deselected, the gate drops in the same cycle, and both counters return to zero.

Top module: `ring_cad_top`

## Requirements
- R1: After reset, `cad_state` is 2'b00 (idle), and `ring_active`, `on_irq` and `off_irq` are all 0.
- R2: When `cad_state` is idle and `ring_sel` is 1 at a clock edge, `cad_state` becomes 2'b01 (ringing) and `ring_active` becomes 1.
- R3: While ringing with `on_en` set, the edge that carries the max(`on_time`,1)-th `tick_ms` pulse of the burst moves `cad_state` to 2'b10 (on-hook transmission) and drops `ring_active`.
- R4: While in on-hook transmission with `off_en` set, the edge that carries the max(`off_time`,1)-th tick of the gap moves `cad_state` back to 2'b01.
- R5: With both enables set and `ring_sel` held, bursts and gaps keep alternating without limit.
- R6: With `on_en` clear, the ringing phase never ends while `ring_sel` is held, and no interrupt is raised.
- R7: With `off_en` clear and `on_en` set, the line stays in on-hook transmission after the first burst.
- R8: When `ring_sel` is 0, `ring_active` is 0 in the same cycle. `cad_state` is idle after the next edge, and both phase counters restart from zero when ringing is selected again.
- R9: The edge where a burst ends gives `on_irq`, and the edge where a gap ends gives `off_irq`. Each is high for exactly one cycle after that edge.
- R10: Durations count up to 8191 ticks without wrapping, and a programmed duration of 0 acts as 1 tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_ms | input | 1 | One-cycle strobe every millisecond |
| ring_sel | input | 1 | Line state selects ringing |
| on_time | input | 13 | Burst length in ticks |
| off_time | input | 13 | Gap length in ticks |
| on_en | input | 1 | Burst timer enable |
| off_en | input | 1 | Gap timer enable |
| ring_active | output | 1 | Gate for the ringing waveform |
| cad_state | output | 2 | 00 idle, 01 ringing, 10 on-hook transmission |
| on_irq | output | 1 | Burst-expiry pulse |
| off_irq | output | 1 | Gap-expiry pulse |

## Verification
The bench counts ticks across several burst and gap cycles. A counter that is off by one shifts the phase, and the bench sees the wrong state or the wrong number of pulses. Zero durations and the 8191 limit are both exercised: a design that lets 0 wrap to a huge count, or that truncates the 13-bit compare, would never expire. Ringing is deselected partway through a burst, and the bench then checks that the restarted burst runs to its full length, which exposes a counter that is not cleared. It also checks that the gate falls in the same cycle as the request. The pulse counts catch an interrupt that is held for more than one cycle.

// File: rtl/ring_cad_pkg.sv
package ring_cad_pkg;

  localparam int CAD_CNT_W = 13;

  typedef enum logic [1:0] {
    CAD_IDLE  = 2'b00,
    CAD_RING  = 2'b01,
    CAD_QUIET = 2'b10
  } cad_state_e;

  // effective limit: a zero duration behaves as one tick
  function automatic logic limit_hit(input int unsigned next_cnt,
                                     input int unsigned limit);
    int unsigned eff;
    eff = (limit == 0) ? 1 : limit;
    return next_cnt >= eff;
  endfunction

endpackage

// File: rtl/ring_cad_timer.sv
module ring_cad_timer #(
  parameter int CNT_W = ring_cad_pkg::CAD_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             en,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             expire
);
  import ring_cad_pkg::*;

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  assign cnt_nxt = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
  assign expire  = run && en && tick && limit_hit(32'(cnt_nxt), 32'(limit));

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (!run || expire)  cnt_q <= '0;
    else if (tick)            cnt_q <= cnt_nxt;
  end

endmodule

// File: rtl/ring_cad_fsm.sv
module ring_cad_fsm (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ring_sel,
  input  logic       on_expire,
  input  logic       off_expire,
  output logic       run_on,
  output logic       run_off,
  output logic       ring_active,
  output logic [1:0] cad_state,
  output logic       on_irq,
  output logic       off_irq
);
  import ring_cad_pkg::*;

  cad_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (!ring_sel) st_d = CAD_IDLE;
    else begin
      unique case (st_q)
        CAD_IDLE:  st_d = CAD_RING;
        CAD_RING:  if (on_expire)  st_d = CAD_QUIET;
        CAD_QUIET: if (off_expire) st_d = CAD_RING;
        default:   st_d = CAD_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= CAD_IDLE;
      on_irq  <= 1'b0;
      off_irq <= 1'b0;
    end else begin
      st_q    <= st_d;
      on_irq  <= on_expire;
      off_irq <= off_expire;
    end
  end

  assign run_on      = ring_sel && (st_q == CAD_RING);
  assign run_off     = ring_sel && (st_q == CAD_QUIET);
  assign ring_active = run_on;
  assign cad_state   = st_q;

endmodule

// File: rtl/ring_cad_top.sv
module ring_cad_top #(
  parameter int CNT_W = ring_cad_pkg::CAD_CNT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_ms,
  input  logic             ring_sel,
  input  logic [CNT_W-1:0] on_time,
  input  logic [CNT_W-1:0] off_time,
  input  logic             on_en,
  input  logic             off_en,
  output logic             ring_active,
  output logic [1:0]       cad_state,
  output logic             on_irq,
  output logic             off_irq
);
  localparam int NUM_TMR = 2;

  logic [NUM_TMR-1:0] run_v;
  logic [NUM_TMR-1:0] en_v;
  logic [NUM_TMR-1:0] exp_v;
  logic [CNT_W-1:0]   lim_v [NUM_TMR];

  // named events for the checker
  logic on_expire;
  logic off_expire;
  logic run_on;
  logic run_off;

  assign run_v    = {run_off, run_on};
  assign en_v     = {off_en, on_en};
  assign lim_v[0] = on_time;
  assign lim_v[1] = off_time;

  assign on_expire  = exp_v[0];
  assign off_expire = exp_v[1];

  for (genvar g = 0; g < NUM_TMR; g++) begin : g_tmr
    ring_cad_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run_v[g]),
      .en     (en_v[g]),
      .tick   (tick_ms),
      .limit  (lim_v[g]),
      .expire (exp_v[g])
    );
  end

  ring_cad_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .ring_sel    (ring_sel),
    .on_expire   (on_expire),
    .off_expire  (off_expire),
    .run_on      (run_on),
    .run_off     (run_off),
    .ring_active (ring_active),
    .cad_state   (cad_state),
    .on_irq      (on_irq),
    .off_irq     (off_irq)
  );

endmodule

// File: rtl/ring_cad_chk.sv
module ring_cad_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ring_sel,
  input logic       on_en,
  input logic       off_en,
  input logic       ring_active,
  input logic [1:0] cad_state,
  input logic       on_irq,
  input logic       off_irq,
  input logic       on_expire,
  input logic       off_expire
);

  a_r2_enter_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (cad_state == 2'b00 && ring_sel) |=> cad_state == 2'b01);

  a_r3_burst_end: assert property (@(posedge clk) disable iff (!rst_n)
    on_expire |=> cad_state == 2'b10);

  a_r4_gap_end: assert property (@(posedge clk) disable iff (!rst_n)
    off_expire |=> cad_state == 2'b01);

  a_r6_endless_ring: assert property (@(posedge clk) disable iff (!rst_n)
    (cad_state == 2'b01 && ring_sel && !on_en) |=> cad_state == 2'b01);

  a_r7_stay_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (cad_state == 2'b10 && ring_sel && !off_en) |=> cad_state == 2'b10);

  a_r8_gate_drop: assert property (@(posedge clk) disable iff (!rst_n)
    !ring_sel |-> !ring_active);

  a_r8_go_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ring_sel |=> cad_state == 2'b00);

  a_r9_on_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    on_irq |=> !on_irq);

  a_r9_off_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    off_irq |=> !off_irq);

  a_r9_on_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(on_irq) |-> $past(cad_state) == 2'b01);

endmodule

bind ring_cad_top ring_cad_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ring_sel    (ring_sel),
  .on_en       (on_en),
  .off_en      (off_en),
  .ring_active (ring_active),
  .cad_state   (cad_state),
  .on_irq      (on_irq),
  .off_irq     (off_irq),
  .on_expire   (on_expire),
  .off_expire  (off_expire)
);

// File: tb/ring_cad_top_tb_top.sv
`timescale 1ns/1ps
module ring_cad_top_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_ms = 1'b0;
  logic        ring_sel = 1'b0;
  logic [12:0] on_time = '0;
  logic [12:0] off_time = '0;
  logic        on_en = 1'b0;
  logic        off_en = 1'b0;
  logic        ring_active;
  logic [1:0]  cad_state;
  logic        on_irq;
  logic        off_irq;

  int total = 0;
  int fails = 0;
  int on_cnt = 0;
  int off_cnt = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ring_cad_top dut_i (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .ring_sel(ring_sel),
    .on_time(on_time), .off_time(off_time), .on_en(on_en), .off_en(off_en),
    .ring_active(ring_active), .cad_state(cad_state),
    .on_irq(on_irq), .off_irq(off_irq)
  );

  typedef struct packed {
    logic [12:0] on_t;
    logic [12:0] off_t;
    logic        on_e;
    logic        off_e;
    logic [15:0] n;
    logic [1:0]  st;
    logic [3:0]  n_on;
    logic [3:0]  n_off;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    '{13'd3, 13'd2, 1'b1, 1'b1, 16'd2,  2'b01, 4'd0, 4'd0}, // R3 mid burst
    '{13'd3, 13'd2, 1'b1, 1'b1, 16'd3,  2'b10, 4'd1, 4'd0}, // R3 burst end
    '{13'd3, 13'd2, 1'b1, 1'b1, 16'd5,  2'b01, 4'd1, 4'd1}, // R4 gap end
    '{13'd3, 13'd2, 1'b1, 1'b1, 16'd11, 2'b01, 4'd2, 4'd2}, // R5 repeat
    '{13'd3, 13'd2, 1'b0, 1'b1, 16'd20, 2'b01, 4'd0, 4'd0}, // R6
    '{13'd3, 13'd2, 1'b1, 1'b0, 16'd20, 2'b10, 4'd1, 4'd0}, // R7
    '{13'd0, 13'd0, 1'b1, 1'b1, 16'd3,  2'b10, 4'd2, 4'd1}, // R10 zero
    '{13'd1, 13'd4, 1'b1, 1'b1, 16'd4,  2'b10, 4'd1, 4'd0}  // R4 partial gap
  };

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic sample_irq();
    if (on_irq)  on_cnt++;
    if (off_irq) off_cnt++;
  endtask

  task automatic do_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tick_ms = 1'b1;
      @(negedge clk) tick_ms = 1'b0;
      sample_irq();
      @(negedge clk);
      sample_irq();
    end
  endtask

  task automatic start_ring();
    @(negedge clk) ring_sel = 1'b0;
    @(negedge clk) ring_sel = 1'b1;
    @(negedge clk);
    on_cnt = 0;
    off_cnt = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      total++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 state", int'(cad_state), 0);
    check("R1 gate", int'(ring_active), 0);
    check("R1 irq", int'({on_irq, off_irq}), 0);
    rst_n = 1'b1;

    for (int v = 0; v < NV; v++) begin
      on_time  = VECS[v].on_t;
      off_time = VECS[v].off_t;
      on_en    = VECS[v].on_e;
      off_en   = VECS[v].off_e;
      start_ring();
      check("R2 enter ringing", int'(cad_state), 1);
      do_ticks(int'(VECS[v].n));
      check("R3/R4 state", int'(cad_state), int'(VECS[v].st));
      check("R9 on_irq count", on_cnt, int'(VECS[v].n_on));
      check("R9 off_irq count", off_cnt, int'(VECS[v].n_off));
      check("R8 gate matches state", int'(ring_active),
            int'(VECS[v].st == 2'b01));
    end

    // R8: drop mid burst, gate falls at once, counter restarts
    on_time = 13'd3; off_time = 13'd2; on_en = 1'b1; off_en = 1'b1;
    start_ring();
    do_ticks(2);
    @(negedge clk) ring_sel = 1'b0;
    #1 check("R8 gate same cycle", int'(ring_active), 0);
    @(negedge clk);
    check("R8 idle", int'(cad_state), 0);
    ring_sel = 1'b1;
    @(negedge clk);
    on_cnt = 0;
    do_ticks(2);
    check("R8 counter cleared", int'(cad_state), 1);
    do_ticks(1);
    check("R8 full burst after restart", int'(cad_state), 2);

    // R10: longest burst
    on_time = 13'd8191; off_time = 13'd5;
    start_ring();
    do_ticks(8190);
    check("R10 still ringing at 8190", int'(cad_state), 1);
    do_ticks(1);
    check("R10 ends at 8191", int'(cad_state), 2);
    check("R10 one pulse", on_cnt, 1);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule